// File: doc/BRIEF.md
# Prioritized Status LED Blink Sequencer

This block drives one status LED so that it tells the board's most urgent condition at a glance. It watches four asynchronous board signals: an active-low external reset request, a supply power-sense input (high means the supplies are good), a shared open-drain power-good line, and an active-high configuration-done flag. Each input is synchronized. The most urgent condition is then picked by fixed priority, and the LED plays that condition's eight-slot on/off pattern. Each slot lasts a programmable number of clock cycles. When the selected condition changes, the pattern starts again at slot zero.

The block also owns its side of the open-drain power-good line. It pulls the line low while the supply sense reports a failure and releases it otherwise, with a pull-up on the board. A carrier may pull the same line low. That is shown only on the LED and has no other effect. The block treats a low on the line as carrier-driven only when it has not driven the line itself during the recent synchronization window. Its own pull-down therefore never shows up as a carrier fault.

The sequencer is a five-state machine with one state per condition: `ST_EXTRST`, `ST_PWRFAIL`, `ST_CARRIER`, `ST_UNCONF` and `ST_READY`. On every cycle the state moves to the condition chosen by priority. A move to a different state is the restart transition: it clears the slot timer and the slot index. Staying in the same state is the hold transition: the slot index advances on each slot tick and wraps after the eighth slot. A synchronous reset forces `ST_READY`, slot zero and the LED off.

Top module: `status_led_sequencer`

## Requirements
- R1: While the external reset input is low, the LED is on in all eight slots, whatever the other inputs are (highest priority).
- R2: When the supply sense is low and no external reset is active, the LED is on for slots 0-4 and off for slots 5-7.
- R3: When the power-good line is pulled low by the carrier, with supply good and no reset, the LED is on for slots 0-3 and off for slots 4-7.
- R4: When configuration-done is low and no higher condition holds, the LED is on for slot 0 only and off for slots 1-7.
- R5: When reset is inactive, supply is good, the line is high and configuration-done is high, the LED stays constantly off.
- R6: `pgood_pull_o` is 1 (drive the line low) while the synchronized supply sense is low and 0 (high impedance) otherwise, with at most four cycles of latency.
- R7: A low on the power-good line caused by the block's own pull-down never selects the carrier pattern, including in the cycles just after the pull-down is released.
- R8: A carrier-driven low on the power-good line changes only the LED; `pgood_pull_o` stays 0.
- R9: Input polarities: the external reset is active low, configuration-done is active high, and a high supply sense means the supply is good.
- R10: When the selected condition changes, the pattern restarts at slot 0, so an on-slot pattern turns the LED on within six cycles of the input change.
- R11: The synchronous reset `rst` turns the LED off, releases the power-good line and clears the slot index by the next cycle.
- R12: Each slot lasts exactly `SLOT_CYCLES` clock cycles, so one full pattern takes 8 x `SLOT_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_rst_n_i | input | 1 | External reset request, active low, asynchronous |
| pwr_ok_i | input | 1 | Supply power sense, high when good, asynchronous |
| pgood_i | input | 1 | Level read back from the open-drain power-good line |
| cfg_done_i | input | 1 | Configuration done, active high, asynchronous |
| pgood_pull_o | output | 1 | 1 = drive the power-good line low, 0 = release it |
| led_o | output | 1 | Status LED, 1 = lit |

## Verification
The assertions check on every cycle how the slot index steps, holds and restarts, that the LED is on in the reset state and off in the ready state, and that the line pull-down agrees with the selected state: never pulling while the carrier pattern is shown, and only pulling in a power-failure or reset state. The whole duty pattern of each condition, the priority order when several conditions hold at once, the timing of the restart after an input change, and the absence of a false carrier indication after the block releases the line are shown only by the bench's scenarios. These scenarios count lit cycles and rising edges over two full pattern periods.

// File: rtl/sled_pkg.sv
package sled_pkg;

    localparam int unsigned SLOTS   = 8;
    localparam int unsigned SLOT_W  = $clog2(SLOTS);

    typedef enum logic [2:0] {
        ST_READY   = 3'd0,
        ST_UNCONF  = 3'd1,
        ST_CARRIER = 3'd2,
        ST_PWRFAIL = 3'd3,
        ST_EXTRST  = 3'd4
    } sled_state_e;

    // Bit n of the mask is the LED level during slot n.
    function automatic logic [SLOTS-1:0] slot_mask(input sled_state_e st);
        logic [SLOTS-1:0] m;
        unique case (st)
            ST_EXTRST:  m = {SLOTS{1'b1}};
            ST_PWRFAIL: m = (SLOTS)'(8'h1F);
            ST_CARRIER: m = (SLOTS)'(8'h0F);
            ST_UNCONF:  m = (SLOTS)'(8'h01);
            default:    m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sled_sync.sv
module sled_sync #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= async_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sled_slot_timer.sv
module sled_slot_timer #(
    parameter int unsigned SLOT_CYCLES = 3_022_500
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);

    localparam int unsigned CW   = $clog2(SLOT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/sled_fsm.sv
module sled_fsm
    import sled_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ext_rst_act,
    input  logic              pwr_fail,
    input  logic              carrier_low,
    input  logic              unconf,
    output sled_state_e       state_q,
    output logic [SLOT_W-1:0] slot_q,
    output logic              restart,
    output logic              led_o
);

    sled_state_e state_d;

    // Fixed priority selection of the next state.
    always_comb begin
        if (ext_rst_act)      state_d = ST_EXTRST;
        else if (pwr_fail)    state_d = ST_PWRFAIL;
        else if (carrier_low) state_d = ST_CARRIER;
        else if (unconf)      state_d = ST_UNCONF;
        else                  state_d = ST_READY;
    end

    assign restart = (state_d != state_q);

    // State and slot register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READY;
            slot_q  <= '0;
        end else if (restart) begin
            state_q <= state_d;
            slot_q  <= '0;
        end else if (tick) begin
            slot_q  <= slot_q + 1'b1;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) led_o <= 1'b0;
        else begin
            unique case (state_q)
                ST_READY: led_o <= 1'b0;
                ST_EXTRST,
                ST_PWRFAIL,
                ST_CARRIER,
                ST_UNCONF: led_o <= slot_mask(state_q)[slot_q];
                default:  led_o <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/status_led_sequencer.sv
module status_led_sequencer
    import sled_pkg::*;
#(
    parameter int unsigned SLOT_CYCLES = 3_022_500,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_rst_n_i,
    input  logic pwr_ok_i,
    input  logic pgood_i,
    input  logic cfg_done_i,
    output logic pgood_pull_o,
    output logic led_o
);

    localparam int unsigned HIST = SYNC_STAGES + 1;

    logic [3:0]        raw_in, sync_in;
    logic              ext_rst_n_s, pwr_ok_s, pgood_s, cfg_done_s;
    logic              pull_q;
    logic [HIST-1:0]   pull_hist_q;
    logic              drove_recently;
    logic              carrier_low;
    logic              slot_tick;
    logic              restart;
    sled_state_e       state_q;
    logic [SLOT_W-1:0] slot_q;

    assign raw_in = {ext_rst_n_i, pwr_ok_i, pgood_i, cfg_done_i};

    sled_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1111)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    assign {ext_rst_n_s, pwr_ok_s, pgood_s, cfg_done_s} = sync_in;

    // Open-drain control plus a short history of our own drive.
    always_ff @(posedge clk) begin
        if (rst) begin
            pull_q      <= 1'b0;
            pull_hist_q <= '0;
        end else begin
            pull_q      <= ~pwr_ok_s;
            pull_hist_q <= {pull_hist_q[HIST-2:0], pull_q};
        end
    end

    assign drove_recently = pull_q | (|pull_hist_q);
    assign carrier_low    = ~pgood_s & ~drove_recently;
    assign pgood_pull_o   = pull_q;

    sled_slot_timer #(
        .SLOT_CYCLES (SLOT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (slot_tick)
    );

    sled_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (slot_tick),
        .ext_rst_act (~ext_rst_n_s),
        .pwr_fail    (~pwr_ok_s),
        .carrier_low (carrier_low),
        .unconf      (~cfg_done_s),
        .state_q     (state_q),
        .slot_q      (slot_q),
        .restart     (restart),
        .led_o       (led_o)
    );

endmodule

// File: rtl/sled_checker.sv
module sled_checker
    import sled_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              led_o,
    input logic              pgood_pull_o,
    input sled_state_e       state_q,
    input logic [SLOT_W-1:0] slot_q,
    input logic              tick,
    input logic              restart
);

    p_extrst_led_on_r1: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_EXTRST |=> led_o);

    p_ready_led_off_r5: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_READY |=> !led_o);

    p_pull_only_fail_r6: assert property (@(posedge clk) disable iff (rst)
        pgood_pull_o |-> (state_q == ST_PWRFAIL || state_q == ST_EXTRST));

    p_carrier_no_pull_r8: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_CARRIER |-> !pgood_pull_o);

    p_restart_slot0_r10: assert property (@(posedge clk) disable iff (rst)
        restart |=> slot_q == '0);

    p_slot_step_r12: assert property (@(posedge clk) disable iff (rst)
        tick && !restart |=> slot_q == $past(slot_q) + 1'b1);

    p_slot_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !tick && !restart |=> $stable(slot_q));

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (!led_o && !pgood_pull_o && slot_q == '0));

endmodule

bind status_led_sequencer sled_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .led_o        (led_o),
    .pgood_pull_o (pgood_pull_o),
    .state_q      (state_q),
    .slot_q       (slot_q),
    .tick         (slot_tick),
    .restart      (restart)
);

// File: tb/tb_status_led_sequencer.sv
`timescale 1ns/1ps
module tb_status_led_sequencer;

    localparam int SLOT   = 5;
    localparam int PERIOD = 8 * SLOT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_rst_n = 1'b1;
    logic pwr_ok = 1'b1;
    logic carrier_pull = 1'b0;
    logic cfg_done = 1'b1;
    logic pgood_line;
    logic pgood_pull;
    logic led;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    assign pgood_line = ~(pgood_pull | carrier_pull);

    status_led_sequencer #(
        .SLOT_CYCLES (SLOT),
        .SYNC_STAGES (2)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .ext_rst_n_i  (ext_rst_n),
        .pwr_ok_i     (pwr_ok),
        .pgood_i      (pgood_line),
        .cfg_done_i   (cfg_done),
        .pgood_pull_o (pgood_pull),
        .led_o        (led)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Lit cycles and rising edges over two full periods.
    task automatic measure(output int ones, output int rises);
        logic prev;
        ones = 0; rises = 0;
        @(negedge clk); prev = led;
        for (int i = 0; i < 2 * PERIOD; i++) begin
            if (prev) ones++;
            @(negedge clk);
            if (led && !prev) rises++;
            prev = led;
        end
    endtask

    task automatic pattern_check(input string req, input int k);
        int ones, rises;
        cyc(PERIOD);
        measure(ones, rises);
        check(ones == 2 * k * SLOT, req, ones, 2 * k * SLOT);
        check(rises == ((k == 0 || k == 8) ? 0 : 2), req, rises,
              (k == 0 || k == 8) ? 0 : 2);
    endtask

    task automatic set_in(input bit rn, input bit po, input bit cp, input bit cd);
        ext_rst_n = rn; pwr_ok = po; carrier_pull = cp; cfg_done = cd;
    endtask

    task automatic t_reset;
        check(led == 1'b0, "R11 led", led, 0);
        check(pgood_pull == 1'b0, "R11 pull", pgood_pull, 0);
        set_in(1'b1, 1'b0, 1'b0, 1'b1);
        cyc(10);
        rst = 1'b1;
        cyc(2);
        check(led == 1'b0, "R11 led under rst", led, 0);
        check(pgood_pull == 1'b0, "R11 pull under rst", pgood_pull, 0);
        rst = 1'b0;
        set_in(1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_ready;
        set_in(1'b1, 1'b1, 1'b0, 1'b1);
        pattern_check("R5 ready off", 0);
    endtask

    task automatic t_unconf;
        set_in(1'b1, 1'b1, 1'b0, 1'b0);
        pattern_check("R4 unconf 1/8", 1);
    endtask

    task automatic t_carrier;
        set_in(1'b1, 1'b1, 1'b1, 1'b0);
        pattern_check("R3 carrier 4/8", 4);
        check(pgood_pull == 1'b0, "R8 no pull on carrier", pgood_pull, 0);
        set_in(1'b1, 1'b1, 1'b0, 1'b1);
        cyc(PERIOD);
    endtask

    task automatic t_pwrfail;
        set_in(1'b1, 1'b0, 1'b1, 1'b0);
        cyc(4);
        check(pgood_pull == 1'b1, "R6 pull on fail", pgood_pull, 1);
        pattern_check("R2 pwrfail 5/8 (R7 own pull)", 5);
        set_in(1'b1, 1'b1, 1'b0, 1'b1);
        cyc(4);
        check(pgood_pull == 1'b0, "R6 release", pgood_pull, 0);
        begin
            int lit = 0;
            for (int i = 0; i < 60; i++) begin
                if (led) lit++;
                @(negedge clk);
            end
            check(lit == 0, "R7 no carrier glitch after release", lit, 0);
        end
    endtask

    task automatic t_priority;
        set_in(1'b0, 1'b0, 1'b1, 1'b0);
        pattern_check("R1 reset over all", 8);
        set_in(1'b0, 1'b1, 1'b0, 1'b1);
        pattern_check("R9 reset active low", 8);
        set_in(1'b1, 1'b1, 1'b0, 1'b1);
        cyc(PERIOD);
    endtask

    task automatic t_restart;
        int wait_n, run;
        set_in(1'b1, 1'b1, 1'b0, 1'b0);
        cyc(PERIOD + 2 * SLOT);
        check(led == 1'b0, "R10 precondition off", led, 0);
        pwr_ok = 1'b0;
        wait_n = 0;
        while (!led && wait_n < 50) begin
            @(negedge clk);
            wait_n++;
        end
        check(wait_n <= 6, "R10 restart delay", wait_n, 6);
        run = 0;
        while (led && run < 100) begin
            @(negedge clk);
            run++;
        end
        check(run == 5 * SLOT, "R12 slot length", run, 5 * SLOT);
        set_in(1'b1, 1'b1, 1'b0, 1'b1);
        cyc(PERIOD);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        t_reset();
        t_ready();
        t_unconf();
        t_carrier();
        t_pwrfail();
        t_priority();
        t_restart();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule